// File: doc/BRIEF.md
# Addressable Control Bit Latch

This block holds a small control register that software changes one bit at a time through a single I/O port. Each write names one bit through a 3-bit select code in the low bits of the write data. The next data bit carries the level to store there. The block sets or clears only that bit and leaves every other bit as it was. A read of the same port returns the whole register. This lets firmware flip one control line without a read-modify-write sequence.

Only five select codes are live, and they do not map straight onto bit indexes. Codes 0, 1 and 2 land on the matching bit. Code 4 lands on bit 3 and code 5 lands on bit 4. Codes 3, 6 and 7 do nothing. The five live bits also leave the block as individual control lines: auxiliary ROM enable, override, startup, boot select and interrupt enable.

Top module: `ctl_bit_latch`

## Requirements
- R1: During a write, wr_data[2:0] is the select code and wr_data[3] is the level to latch. Bits 7..4 of wr_data have no effect.
- R2: A write with select code 5 sets control bit 4 (interrupt enable) to the written level.
- R3: A write with select code 0 drives bit 0, code 1 drives bit 1, code 2 drives bit 2 and code 4 drives bit 3.
- R4: A write with select code 3, 6 or 7 leaves the whole register unchanged, whatever level it carries.
- R5: While port_sel and rd_stb are both high, rd_data equals the current register value. Otherwise rd_data is 0x00.
- R6: An active-low reset clears the register to 0x00.
- R7: Register bits 7..5 are never written and always read as zero.
- R8: A write takes effect at the clock edge that samples port_sel and wr_stb high, and it changes no bit other than the selected one.
- R9: A write strobe while port_sel is low has no effect on the register.
- R10: aux_rom_en, override_o, startup, boot_sel and irq_en always equal register bits 0, 1, 2, 3 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | Port is addressed this cycle |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Select code in bits 2..0, level in bit 3 |
| rd_data | output | 8 | Register value during a selected read, else zero |
| irq_en | output | 1 | Interrupt enable (bit 4) |
| boot_sel | output | 1 | Boot select (bit 3) |
| startup | output | 1 | Startup (bit 2) |
| override_o | output | 1 | Override (bit 1) |
| aux_rom_en | output | 1 | Auxiliary ROM enable (bit 0) |

## Verification
The bench builds the block at its default parameter values: an 8-bit register and a 3-bit select code. At that size all eight select codes and both levels can be driven in every combination. This covers each live slot, each ignored code and the unused upper bits in a handful of cycles. A long run of random strobes and data then compares every output against a behavioural model on each clock. That run reaches mixed reads and writes, writes without select, and writes whose upper data bits are set.

// File: rtl/clb_pkg.sv
package clb_pkg;

  localparam int unsigned CODE_W = 3;

  localparam int unsigned POS_AUX  = 0;
  localparam int unsigned POS_OVR  = 1;
  localparam int unsigned POS_STRT = 2;
  localparam int unsigned POS_BOOT = 3;
  localparam int unsigned POS_IRQ  = 4;

  typedef struct packed {
    logic       hit;
    logic [2:0] pos;
  } slot_t;

  // Select code to register slot. The mapping is deliberately not the identity.
  function automatic slot_t slot_of(input logic [CODE_W-1:0] code);
    slot_t s;
    s = '{hit: 1'b0, pos: 3'd0};
    case (code)
      3'd0: s = '{hit: 1'b1, pos: 3'(POS_AUX)};
      3'd1: s = '{hit: 1'b1, pos: 3'(POS_OVR)};
      3'd2: s = '{hit: 1'b1, pos: 3'(POS_STRT)};
      3'd4: s = '{hit: 1'b1, pos: 3'(POS_BOOT)};
      3'd5: s = '{hit: 1'b1, pos: 3'(POS_IRQ)};
      default: s = '{hit: 1'b0, pos: 3'd0};
    endcase
    return s;
  endfunction

  // True when some select code reaches register position idx.
  function automatic logic bit_used(input int unsigned idx);
    slot_t s;
    logic  r;
    r = 1'b0;
    for (int c = 0; c < (1 << CODE_W); c++) begin
      s = slot_of(CODE_W'(c));
      if (s.hit && (int'(s.pos) == int'(idx))) r = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/clb_decode.sv
module clb_decode
  import clb_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              wr_fire,
  input  logic [CODE_W-1:0] code,
  input  logic              level,
  output logic [CTRL_W-1:0] upd_mask,
  output logic              upd_val
);

  localparam logic [CTRL_W-1:0] ONE = CTRL_W'(1);

  slot_t slot;

  always_comb begin
    slot     = slot_of(code);
    upd_mask = '0;
    if (wr_fire && slot.hit) upd_mask = ONE << slot.pos;
    upd_val  = level;
  end

endmodule

// File: rtl/clb_store.sv
module clb_store
  import clb_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] upd_mask,
  input  logic              upd_val,
  output logic [CTRL_W-1:0] ctl_q
);

  for (genvar i = 0; i < int'(CTRL_W); i++) begin : g_bit
    if (bit_used(i)) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)           ctl_q[i] <= 1'b0;
        else if (upd_mask[i]) ctl_q[i] <= upd_val;
      end
    end else begin : g_dead
      logic unused_mask;
      assign unused_mask = upd_mask[i];
      assign ctl_q[i]    = 1'b0;
    end
  end

endmodule

// File: rtl/ctl_bit_latch.sv
module ctl_bit_latch
  import clb_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq_en,
  output logic              boot_sel,
  output logic              startup,
  output logic              override_o,
  output logic              aux_rom_en
);

  localparam int unsigned LVL_BIT = CODE_W;

  logic              wr_fire;
  logic              rd_fire;
  logic [CODE_W-1:0] wr_code;
  logic              wr_level;
  logic [CTRL_W-1:0] upd_mask;
  logic              upd_val;
  logic [CTRL_W-1:0] ctl_q;
  logic              unused_hi;

  assign wr_fire   = port_sel & wr_stb;
  assign rd_fire   = port_sel & rd_stb;
  assign wr_code   = wr_data[CODE_W-1:0];
  assign wr_level  = wr_data[LVL_BIT];
  assign unused_hi = ^wr_data[CTRL_W-1:LVL_BIT+1];

  clb_decode #(.CTRL_W(CTRL_W)) u_dec (
    .wr_fire (wr_fire),
    .code    (wr_code),
    .level   (wr_level),
    .upd_mask(upd_mask),
    .upd_val (upd_val)
  );

  clb_store #(.CTRL_W(CTRL_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_mask(upd_mask),
    .upd_val (upd_val),
    .ctl_q   (ctl_q)
  );

  assign rd_data    = rd_fire ? ctl_q : '0;
  assign aux_rom_en = ctl_q[POS_AUX];
  assign override_o = ctl_q[POS_OVR];
  assign startup    = ctl_q[POS_STRT];
  assign boot_sel   = ctl_q[POS_BOOT];
  assign irq_en     = ctl_q[POS_IRQ];

endmodule

// File: rtl/clb_checker.sv
module clb_checker #(
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_sel,
  input logic              wr_stb,
  input logic [2:0]        wr_code,
  input logic              wr_level,
  input logic [CTRL_W-1:0] upd_mask,
  input logic [CTRL_W-1:0] ctl_q
);

  logic wr_fire;
  assign wr_fire = port_sel && wr_stb;

  assert_ignored_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (wr_code == 3'd3 || wr_code == 3'd6 || wr_code == 3'd7)) |=> $stable(ctl_q));

  assert_no_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_sel) |=> $stable(ctl_q));

  assert_irq_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_code == 3'd5) |=> (ctl_q[4] == $past(wr_level)));

  assert_boot_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_code == 3'd4) |=> (ctl_q[3] == $past(wr_level)));

  assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_mask));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q >> 5) == '0));

  assert_single_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ctl_q ^ $past(ctl_q)) <= 1));

endmodule

bind ctl_bit_latch clb_checker #(.CTRL_W(CTRL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .port_sel(port_sel),
  .wr_stb  (wr_stb),
  .wr_code (wr_data[2:0]),
  .wr_level(wr_data[3]),
  .upd_mask(upd_mask),
  .ctl_q   (ctl_q)
);

// File: tb/tb_ctl_bit_latch.sv
`timescale 1ns/1ps
module tb_ctl_bit_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_en, boot_sel, startup, override_o, aux_rom_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  ctl_bit_latch dut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .boot_sel(boot_sel), .startup(startup),
    .override_o(override_o), .aux_rom_en(aux_rom_en)
  );

  // Slot lookup restated as a table of positions, -1 for unused codes.
  function automatic int pos_for(input int code);
    int tbl [8] = '{0, 1, 2, -1, 3, 4, -1, -1};
    return tbl[code];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    logic [7:0] exp_rd;
    exp_rd = (port_sel && rd_stb) ? model : 8'h00;
    check({req, " R5 rd_data"}, rd_data, exp_rd);
    check({req, " R10 outputs"}, {3'b000, irq_en, boot_sel, startup, override_o, aux_rom_en},
          {3'b000, model[4:0]});
  endtask

  task automatic cyc(input logic s, input logic r, input logic w, input logic [7:0] d,
                     input string req);
    int p;
    @(negedge clk);
    port_sel = s; rd_stb = r; wr_stb = w; wr_data = d;
    @(posedge clk);
    if (!rst_n) model = 8'h00;
    else if (s && w) begin
      p = pos_for(int'(d[2:0]));
      if (p >= 0) model[p] = d[3];
    end
    #5;
    compare_all(req);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R6: reset state
    cyc(1, 1, 0, 8'h00, "R6 reset");
    cyc(1, 1, 0, 8'h00, "R6 reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1, 0, 8'h00, "R6 after reset");
    check("R6 reset value", rd_data, 8'h00);

    // R2 R3 R1: each code with level 1, then level 0
    for (int c = 0; c < 8; c++) cyc(1, 1, 1, 8'(8'h08 | c), "R2 R3 set");
    check("R3 all live bits set", rd_data, 8'h1F);
    for (int c = 0; c < 8; c++) begin
      cyc(1, 1, 1, 8'(c), "R3 clear");
    end
    check("R3 all clear", rd_data, 8'h00);

    // R2: interrupt enable alone
    cyc(1, 1, 1, 8'h0D, "R2 irq");
    check("R2 irq bit", {7'd0, irq_en}, 8'h01);
    cyc(1, 1, 1, 8'h05, "R2 irq clr");
    check("R2 irq cleared", {7'd0, irq_en}, 8'h00);

    // R1 R7: upper data bits set must not leak
    cyc(1, 1, 1, 8'hF9, "R1 upper bits");
    check("R1 R7 code1 only", rd_data, 8'h02);
    cyc(1, 1, 1, 8'hF1, "R1 clr");

    // R4: ignored codes with both levels
    cyc(1, 1, 1, 8'h0C, "R4 setup");
    cyc(1, 1, 1, 8'h08, "R4 setup");
    foreach (pos_for_codes[k]) begin end
    cyc(1, 1, 1, 8'h0B, "R4 code3");
    cyc(1, 1, 1, 8'h0E, "R4 code6");
    cyc(1, 1, 1, 8'h0F, "R4 code7");
    cyc(1, 1, 1, 8'h03, "R4 code3 lo");
    check("R4 unchanged", rd_data, 8'h09);

    // R9: write strobe without select
    cyc(0, 0, 1, 8'h0D, "R9 nosel");
    cyc(0, 0, 1, 8'h00, "R9 nosel");
    cyc(1, 1, 0, 8'h00, "R9 read back");
    check("R9 unchanged", rd_data, 8'h09);

    // R5: no read strobe gives zero
    cyc(1, 0, 0, 8'h00, "R5 no rd");
    check("R5 idle zero", rd_data, 8'h00);

    // R8: timing - write sampled at edge, visible right after
    cyc(1, 1, 1, 8'h0A, "R8 write");
    check("R8 immediate", rd_data, 8'h0D);

    // R8 R9 R4: random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ctl;
      ctl = 4'($urandom);
      cyc(ctl[0], ctl[1], ctl[2] | ctl[3], 8'($urandom), "R8 random");
    end

    // R6: reset mid-run
    cyc(1, 1, 1, 8'h0D, "R6 pre");
    @(negedge clk); rst_n = 1'b0;
    cyc(1, 1, 0, 8'h00, "R6 mid reset");
    check("R6 cleared", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1, 0, 8'h00, "R6 post");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int pos_for_codes [1] = '{0};

endmodule